// File: doc/BRIEF.md
# Ternary Covering-Lookup Match Array

This block is a small ternary content-addressable match array. Each stored word is a row of ternary symbols, and so is the search key. That lets one table answer two kinds of query. The first is an ordinary longest-prefix lookup with a fully binary key. The second finds the stored entry that covers a ternary key, where the key's wildcard positions must meet wildcards in the entry.

The storage side and the search side encode the wildcard differently. A stored wildcard accepts any key symbol. A key wildcard is accepted only by a stored wildcard.

Software loads entries one at a time through a write port that carries an index, a word and a valid flag. Software keeps longer prefixes at lower indices, because the block always reports the matching entry with the smallest index. A search strobe samples the key together with the table contents present in that cycle. The hit flag and winning index appear on the next clock and hold until the next strobe.

Top module: `tcam_cover_lookup`

## Requirements
- R1: Each symbol is two bits: 00 stored wildcard, 01 zero, 10 one, 11 key wildcard. Symbol 0 of a word is its most significant pair. A key zero matches a stored zero or a stored wildcard, and a key one matches a stored one or a stored wildcard.
- R2: A key wildcard (11), and likewise an unused key code 00, matches only a stored wildcard. It never matches a stored zero or a stored one.
- R3: A stored code 11 never matches any key symbol.
- R4: A word matches only if every one of its symbol positions matches. A single mismatching position is enough to reject the word.
- R5: When several valid words match, the reported index is the lowest matching index.
- R6: Every entry carries a valid bit, and invalid entries never match. After reset all entries are invalid and the outputs show no hit with index 0. Writing with the valid flag low removes an entry.
- R7: The result of a search strobe appears on the outputs on the clock edge after the strobe and holds unchanged while no strobe is given, even if the key or the table changes.
- R8: When no valid word matches, the hit flag is low and the index is 0.
- R9: A write is seen by searches strobed in the following cycle or later. A search strobed in the same cycle as a write sees the previous contents.
- R10: With entries 1000*, 100* and 10* at increasing indices, the binary key 10000000 returns the 1000* entry. The key 100 followed by wildcards returns the 100* entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDXW | Entry index to write |
| wr_word | input | 2*KEY_SYMS | Ternary word to store |
| wr_valid | input | 1 | Valid flag stored with the word |
| srch_en | input | 1 | Search strobe |
| srch_key | input | 2*KEY_SYMS | Ternary search key |
| hit | output | 1 | A valid entry matched the last strobed key |
| hit_idx | output | IDXW | Lowest matching index, 0 on a miss |

## Verification
The bench checks the asymmetric wildcard rule in both directions. A design that treated the key wildcard like a stored one would report covering hits against entries holding a 0 or 1 at that position. It also probes a stored 11, which an equality-based comparator would wrongly accept against a key wildcard. A word that differs only in its last symbol exposes a match line that ignores a position. Overlapping prefixes, plus removing the leading one, catch an encoder that favours the highest index. A write and a search issued in the same cycle catch a comparator that reads the freshly written word. Idle cycles with a changing key and table catch outputs that are not held between strobes.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    localparam logic [1:0] SYM_STORE_ANY = 2'b00;
    localparam logic [1:0] SYM_ZERO      = 2'b01;
    localparam logic [1:0] SYM_ONE       = 2'b10;
    localparam logic [1:0] SYM_KEY_ANY   = 2'b11;

    // Cell compare: stored wildcard accepts anything; stored 0/1 accepts
    // only the identical key code; stored 11 accepts nothing.
    function automatic logic sym_match(input logic [1:0] stored, input logic [1:0] key);
        logic m;
        unique case (stored)
            SYM_STORE_ANY: m = 1'b1;
            SYM_ZERO:      m = (key == SYM_ZERO);
            SYM_ONE:       m = (key == SYM_ONE);
            default:       m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
    parameter int ENTRIES = 16,
    parameter int WW      = 16,
    parameter int IDXW    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDXW-1:0]                wr_idx,
    input  logic [WW-1:0]                  wr_word,
    input  logic                           wr_valid,
    output logic [ENTRIES-1:0][WW-1:0]     words,
    output logic [ENTRIES-1:0]             vld
);

    typedef struct packed {
        logic [ENTRIES-1:0][WW-1:0] word;
        logic [ENTRIES-1:0]         vld;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && (wr_idx == IDXW'(i))) begin
                st_d.word[i] = wr_word;
                st_d.vld[i]  = wr_valid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words = st_q.word;
    assign vld   = st_q.vld;

endmodule

// File: rtl/tcam_match_row.sv
module tcam_match_row #(
    parameter int KEY_SYMS = 8
) (
    input  logic [2*KEY_SYMS-1:0] word,
    input  logic                  valid,
    input  logic [2*KEY_SYMS-1:0] key,
    output logic                  match
);
    import tcam_pkg::*;

    logic [KEY_SYMS-1:0] cell_ok;

    for (genvar s = 0; s < KEY_SYMS; s++) begin : g_cell
        assign cell_ok[s] = sym_match(word[2*s +: 2], key[2*s +: 2]);
    end

    // Shared match line: any failing cell pulls the word low.
    assign match = valid & (&cell_ok);

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
    parameter int ENTRIES = 16,
    parameter int IDXW    = 4
) (
    input  logic [ENTRIES-1:0] req,
    output logic               any,
    output logic [IDXW-1:0]    idx
);

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDXW'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/tcam_cover_lookup.sv
module tcam_cover_lookup #(
    parameter int KEY_SYMS = 8,
    parameter int ENTRIES  = 16,
    localparam int WW      = 2 * KEY_SYMS,
    localparam int IDXW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [WW-1:0]   wr_word,
    input  logic            wr_valid,
    input  logic            srch_en,
    input  logic [WW-1:0]   srch_key,
    output logic            hit,
    output logic [IDXW-1:0] hit_idx
);

    logic [ENTRIES-1:0][WW-1:0] words;
    logic [ENTRIES-1:0]         vld;
    logic [ENTRIES-1:0]         mline;
    logic                       any_m;
    logic [IDXW-1:0]            win_idx;

    tcam_store #(.ENTRIES(ENTRIES), .WW(WW), .IDXW(IDXW)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_word  (wr_word),
        .wr_valid (wr_valid),
        .words    (words),
        .vld      (vld)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_row
        tcam_match_row #(.KEY_SYMS(KEY_SYMS)) row_i (
            .word  (words[e]),
            .valid (vld[e]),
            .key   (srch_key),
            .match (mline[e])
        );
    end

    tcam_prio_enc #(.ENTRIES(ENTRIES), .IDXW(IDXW)) enc_i (
        .req (mline),
        .any (any_m),
        .idx (win_idx)
    );

    typedef struct packed {
        logic            hit;
        logic [IDXW-1:0] idx;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (srch_en) begin
            res_d.hit = any_m;
            res_d.idx = any_m ? win_idx : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit     = res_q.hit;
    assign hit_idx = res_q.idx;

endmodule

// File: rtl/tcam_cover_lookup_chk.sv
module tcam_cover_lookup_chk #(
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            srch_en,
    input logic            hit,
    input logic [IDXW-1:0] hit_idx
);

    AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0)); // R8

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> ($stable(hit) && $stable(hit_idx))); // R7

    AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(srch_en)); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!hit && hit_idx == '0)); // R6

endmodule

bind tcam_cover_lookup tcam_cover_lookup_chk #(.IDXW(IDXW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .srch_en (srch_en),
    .hit     (hit),
    .hit_idx (hit_idx)
);

// File: tb/tcam_cover_lookup_tb_top.sv
module tcam_cover_lookup_tb_top;

    localparam int KS   = 8;
    localparam int NE   = 16;
    localparam int WW   = 2 * KS;
    localparam int IDXW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [IDXW-1:0] wr_idx = '0;
    logic [WW-1:0]   wr_word = '0;
    logic            wr_valid = 1'b0;
    logic            srch_en = 1'b0;
    logic [WW-1:0]   srch_key = '0;
    logic            hit;
    logic [IDXW-1:0] hit_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tcam_cover_lookup #(.KEY_SYMS(KS), .ENTRIES(NE)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_word(wr_word), .wr_valid(wr_valid), .srch_en(srch_en),
        .srch_key(srch_key), .hit(hit), .hit_idx(hit_idx)
    );

    // '0'->01 '1'->10 '*'->00 (stored wildcard) 'x'/'b'->11; leftmost char is symbol 0 (MSB pair)
    function automatic logic [WW-1:0] enc(input string s);
        logic [WW-1:0] v = '0;
        for (int i = 0; i < KS; i++) begin
            logic [1:0] c;
            case (s[i])
                "0": c = 2'b01;
                "1": c = 2'b10;
                "*": c = 2'b00;
                default: c = 2'b11;
            endcase
            v[WW-1-2*i -: 2] = c;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic eh, input logic [IDXW-1:0] ei);
        n_chk++;
        if (hit !== eh || hit_idx !== ei) begin
            n_bad++;
            $display("FAIL %s: got hit=%0b idx=%0d, expected hit=%0b idx=%0d",
                     req, hit, hit_idx, eh, ei);
        end
    endtask

    task automatic wr(input int idx, input string s, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDXW'(idx); wr_word = enc(s); wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NE; i++) wr(i, "********", 1'b0);
    endtask

    task automatic search(input string k);
        @(negedge clk);
        srch_en = 1'b1; srch_key = enc(k);
        @(negedge clk);
        srch_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R6 reset", 1'b0, '0);
        search("00000000");
        check("R6 empty table", 1'b0, '0);
        search("********");
        check("R6 empty table stored-wild key", 1'b0, '0);
    endtask

    task automatic t_symbols();
        clear_all();
        wr(0, "01******", 1'b1);
        search("01000000");
        check("R1 binary key on 0/1/wild", 1'b1, 4'd0);
        search("11000000");
        check("R1 key 1 vs stored 0", 1'b0, '0);
        search("0x000000");
        check("R2 key wildcard vs stored 1", 1'b0, '0);
        search("01xxxxxx");
        check("R2 key wildcard vs stored wildcard", 1'b1, 4'd0);
        wr(0, "0*******", 1'b1);
        search("0*000000");
        check("R2 key 00 vs stored wildcard", 1'b1, 4'd0);
        search("*0000000");
        check("R2 key 00 vs stored 0", 1'b0, '0);
    endtask

    task automatic t_stored11();
        clear_all();
        wr(1, "b*******", 1'b1);
        search("00000000");
        check("R3 stored 11 vs key 0", 1'b0, '0);
        search("10000000");
        check("R3 stored 11 vs key 1", 1'b0, '0);
        search("xxxxxxxx");
        check("R3 stored 11 vs key wildcard", 1'b0, '0);
    endtask

    task automatic t_word();
        clear_all();
        wr(2, "10101010", 1'b1);
        search("10101011");
        check("R4 last symbol differs", 1'b0, '0);
        search("00101010");
        check("R4 first symbol differs", 1'b0, '0);
        search("10101010");
        check("R4 full match", 1'b1, 4'd2);
    endtask

    task automatic t_prefix();
        clear_all();
        wr(3, "1000****", 1'b1);
        wr(4, "100*****", 1'b1);
        wr(5, "10******", 1'b1);
        search("10000000");
        check("R10 R5 binary key longest prefix", 1'b1, 4'd3);
        search("100xxxxx");
        check("R10 covering key", 1'b1, 4'd4);
        search("10111111");
        check("R5 only shortest prefix", 1'b1, 4'd5);
        search("01111111");
        check("R8 miss after hit", 1'b0, '0);
        wr(3, "1000****", 1'b0);
        search("10000000");
        check("R6 invalidated entry skipped", 1'b1, 4'd4);
    endtask

    task automatic t_same_cycle();
        // entry 3 invalid, entries 4 and 5 valid from t_prefix
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd0; wr_word = enc("10000000"); wr_valid = 1'b1;
        srch_en = 1'b1; srch_key = enc("10000000");
        @(negedge clk);
        wr_en = 1'b0; srch_en = 1'b0;
        check("R9 search sees old contents", 1'b1, 4'd4);
        search("10000000");
        check("R9 write visible next search", 1'b1, 4'd0);
    endtask

    task automatic t_hold();
        search("10111111");
        check("R7 result after strobe", 1'b1, 4'd5);
        @(negedge clk);
        srch_key = enc("00000000");
        wr_en = 1'b1; wr_idx = 4'd5; wr_word = enc("10******"); wr_valid = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R7 held without strobe", 1'b1, 4'd5);
        search("10111111");
        check("R7 new strobe updates", 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_symbols();
        t_stored11();
        t_word();
        t_prefix();
        t_same_cycle();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule